// File: doc/BRIEF.md
# Radix-4 Decimation-in-Frequency Butterfly

This block is the arithmetic core of a radix-4 fast Fourier transform stage. On each accepted handshake it takes four complex samples and three complex twiddle factors and returns four complex results. It first forms a four-point DFT using only sign changes and real/imaginary swaps, so that stage needs no multipliers. It then scales the four sums down by four to leave headroom. The three sums other than the first are then multiplied by their twiddle factors. The first result uses a unity twiddle and skips the multiplier.

All arithmetic is signed fixed point with 16-bit real and imaginary parts (one sign bit, fifteen fraction bits). Samples, twiddles and results are each carried as one 32-bit word. The block is fully pipelined with a valid/ready handshake. With no back-pressure it accepts one butterfly per cycle and each result appears four cycles after acceptance. Twiddle storage, address generation and stage sequencing are left to the surrounding FFT engine.

Top module: `r4bf_butterfly`

## Requirements
- R1: Every 32-bit sample and result word carries its real part in bits [31:16] and its imaginary part in bits [15:0], both two's complement. A twiddle word carries the cosine in bits [31:16] and the sine in bits [15:0], and stands for the factor cos − j·sin.
- R2: Result 0 equals (a + b + c + d) with each part scaled by the rule of R6 and no twiddle multiply applied.
- R3: Result 2 equals the scaled (a − b + c − d) multiplied by twiddle 2.
- R4: Result 1 equals the scaled (a − j·b − c + j·d) multiplied by twiddle 1. Here multiplying by −j maps (re, im) to (im, −re) and multiplying by +j maps (re, im) to (−im, re).
- R5: Result 3 equals the scaled (a + j·b − c − j·d) multiplied by twiddle 3.
- R6: Each part of a four-term sum is formed exactly and then shifted right arithmetically by 2 (rounding toward minus infinity). Every input combination fits in 16 bits without wrap, including full-scale negative inputs.
- R7: A twiddle product is (x_re·cos + x_im·sin) + j(x_im·cos − x_re·sin), computed exactly. Each part gets 2^14 added, is shifted right arithmetically by 15, and is clamped to [−32768, 32767].
- R8: A butterfly accepted at a clock edge appears on the outputs after four edges plus one edge for every stalled cycle in between. Results leave in acceptance order, and with out_ready held high one butterfly is accepted every cycle.
- R9: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the outputs and out_valid hold their values.
- R10: While rst_n is low and after it is released, out_valid is 0 and in_ready is 1 until the first result arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input butterfly present |
| in_ready | output | 1 | Block can take a butterfly this cycle |
| in_x0 | input | 32 | Sample a |
| in_x1 | input | 32 | Sample b |
| in_x2 | input | 32 | Sample c |
| in_x3 | input | 32 | Sample d |
| in_w1 | input | 32 | Twiddle for result 1 |
| in_w2 | input | 32 | Twiddle for result 2 |
| in_w3 | input | 32 | Twiddle for result 3 |
| out_valid | output | 1 | Result set present |
| out_ready | input | 1 | Consumer takes the result set this cycle |
| out_y0 | output | 32 | Result 0 (unity twiddle) |
| out_y1 | output | 32 | Result 1 |
| out_y2 | output | 32 | Result 2 |
| out_y3 | output | 32 | Result 3 |

## Verification
Some properties are checked on every cycle: the ready rule, holding of outputs under back-pressure, idleness out of reset, the bound of four butterflies in flight, and the four-cycle latency of the unity lane with its scaled sum. Only the bench scenarios can show the exact rotated sums, the rounding and clamping of the twiddle products, and the latency growth under random stalls. The bench checks these against its own integer model, with directed cases at full-scale inputs and at the clamp point.

// File: rtl/r4bf_pkg.sv
package r4bf_pkg;

  localparam int CW    = 16;          // bits per real or imaginary part
  localparam int WW    = 2 * CW;      // packed complex word
  localparam int GROW  = 2;           // headroom for a four-term sum
  localparam int SW    = CW + GROW;   // exact sum width
  localparam int SCALE = 2;           // right shift applied per butterfly
  localparam int FRAC  = CW - 1;      // fraction bits of the Q1.15 format
  localparam int PW    = 2 * CW;      // exact product width
  localparam int AW    = PW + 1;      // product sum width
  localparam int LANES = 4;
  localparam int TWN   = LANES - 1;   // lanes that carry a twiddle
  localparam int DEPTH = 4;           // pipeline register stages

  localparam logic signed [AW-1:0] HALF_LSB = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] SAT_HI   = AW'(2 ** (CW - 1) - 1);
  localparam logic signed [AW-1:0] SAT_LO   = -SAT_HI - AW'(1);

  typedef struct packed {
    logic signed [CW-1:0] re;
    logic signed [CW-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [SW-1:0] re;
    logic signed [SW-1:0] im;
  } wide_t;

  typedef struct packed {
    logic signed [PW-1:0] rc;  // x.re * cos
    logic signed [PW-1:0] si;  // x.im * sin
    logic signed [PW-1:0] ic;  // x.im * cos
    logic signed [PW-1:0] rs;  // x.re * sin
  } prod_t;

  function automatic wide_t widen(input cplx_t x);
    wide_t w;
    w.re = {{GROW{x.re[CW-1]}}, x.re};
    w.im = {{GROW{x.im[CW-1]}}, x.im};
    return w;
  endfunction

  function automatic wide_t wadd(input wide_t p, input wide_t q);
    wide_t r;
    r.re = p.re + q.re;
    r.im = p.im + q.im;
    return r;
  endfunction

  function automatic wide_t wsub(input wide_t p, input wide_t q);
    wide_t r;
    r.re = p.re - q.re;
    r.im = p.im - q.im;
    return r;
  endfunction

  // multiply by -j: swap the halves and negate the new imaginary part
  function automatic wide_t rot_nj(input wide_t x);
    wide_t r;
    r.re = x.im;
    r.im = -x.re;
    return r;
  endfunction

  // multiply by +j: swap the halves and negate the new real part
  function automatic wide_t rot_pj(input wide_t x);
    wide_t r;
    r.re = -x.im;
    r.im = x.re;
    return r;
  endfunction

  // exact four-point DFT term for output lane k
  function automatic wide_t dft_lane(input int k, input cplx_t a, input cplx_t b,
                                     input cplx_t c, input cplx_t d);
    wide_t wa, wb, wc, wd, r;
    wa = widen(a);
    wb = widen(b);
    wc = widen(c);
    wd = widen(d);
    case (k)
      0:       r = wadd(wadd(wa, wb), wadd(wc, wd));
      1:       r = wadd(wsub(wadd(wa, rot_nj(wb)), wc), rot_pj(wd));
      2:       r = wsub(wadd(wa, wc), wadd(wb, wd));
      default: r = wadd(wsub(wadd(wa, rot_pj(wb)), wc), rot_nj(wd));
    endcase
    return r;
  endfunction

  function automatic logic signed [CW-1:0] shrink(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = v >>> SCALE;
    return t[CW-1:0];
  endfunction

  function automatic cplx_t scale_down(input wide_t s);
    cplx_t r;
    r.re = shrink(s.re);
    r.im = shrink(s.im);
    return r;
  endfunction

  function automatic prod_t twiddle_products(input cplx_t x, input cplx_t w);
    prod_t p;
    p.rc = PW'(x.re) * PW'(w.re);
    p.si = PW'(x.im) * PW'(w.im);
    p.ic = PW'(x.im) * PW'(w.re);
    p.rs = PW'(x.re) * PW'(w.im);
    return p;
  endfunction

  function automatic logic signed [CW-1:0] round_sat(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] t;
    t = (v + HALF_LSB) >>> FRAC;
    if (t > SAT_HI) t = SAT_HI;
    else if (t < SAT_LO) t = SAT_LO;
    return t[CW-1:0];
  endfunction

  // (x.re + j x.im) * (cos - j sin)
  function automatic cplx_t combine(input prod_t p);
    cplx_t r;
    r.re = round_sat(AW'(p.rc) + AW'(p.si));
    r.im = round_sat(AW'(p.ic) - AW'(p.rs));
    return r;
  endfunction

endpackage

// File: rtl/r4bf_ctrl.sv
module r4bf_ctrl #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic adv,
  output logic out_valid
);

  logic [STAGES-1:0] vld_q;

  assign out_valid = vld_q[STAGES-1];
  // the whole pipe moves together unless the last stage is blocked
  assign adv = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (adv) vld_q <= {vld_q[STAGES-2:0], in_valid};
  end

endmodule

// File: rtl/r4bf_delay.sv
module r4bf_delay #(
  parameter int W      = 32,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else if (adv) pipe_q[s] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else if (adv) pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/r4bf_dft4.sv
module r4bf_dft4 import r4bf_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  cplx_t a,
  input  cplx_t b,
  input  cplx_t c,
  input  cplx_t d,
  output cplx_t y [LANES]
);

  wide_t sum_w [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sum_w[k] = dft_lane(k, a, b, c, d);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y[k] <= '0;
      else if (adv) y[k] <= scale_down(sum_w[k]);
    end
  end

endmodule

// File: rtl/r4bf_twmul.sv
module r4bf_twmul import r4bf_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  cplx_t x,
  input  cplx_t w,
  output cplx_t y
);

  prod_t prod_w, prod_q;
  cplx_t rnd_w;

  assign prod_w = twiddle_products(x, w);
  assign rnd_w  = combine(prod_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      y      <= '0;
    end else if (adv) begin
      prod_q <= prod_w;
      y      <= rnd_w;
    end
  end

endmodule

// File: rtl/r4bf_butterfly.sv
module r4bf_butterfly import r4bf_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [WW-1:0] in_x0,
  input  logic [WW-1:0] in_x1,
  input  logic [WW-1:0] in_x2,
  input  logic [WW-1:0] in_x3,
  input  logic [WW-1:0] in_w1,
  input  logic [WW-1:0] in_w2,
  input  logic [WW-1:0] in_w3,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_y0,
  output logic [WW-1:0] out_y1,
  output logic [WW-1:0] out_y2,
  output logic [WW-1:0] out_y3
);

  logic  adv_w;
  cplx_t x_in  [LANES];
  cplx_t w_in  [TWN];
  cplx_t x_q   [LANES];
  cplx_t w_q   [TWN];
  cplx_t w_al  [TWN];
  cplx_t dft_w [LANES];
  cplx_t res_w [LANES];

  assign x_in[0] = cplx_t'(in_x0);
  assign x_in[1] = cplx_t'(in_x1);
  assign x_in[2] = cplx_t'(in_x2);
  assign x_in[3] = cplx_t'(in_x3);
  assign w_in[0] = cplx_t'(in_w1);
  assign w_in[1] = cplx_t'(in_w2);
  assign w_in[2] = cplx_t'(in_w3);

  r4bf_ctrl #(.STAGES(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .adv       (adv_w),
    .out_valid (out_valid)
  );

  assign in_ready = adv_w;

  // stage 1: capture samples and twiddles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LANES; k++) x_q[k] <= '0;
      for (int k = 0; k < TWN; k++)   w_q[k] <= '0;
    end else if (adv_w) begin
      for (int k = 0; k < LANES; k++) x_q[k] <= x_in[k];
      for (int k = 0; k < TWN; k++)   w_q[k] <= w_in[k];
    end
  end

  // stage 2: multiplier-free four-point DFT with scaling
  r4bf_dft4 u_dft (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv_w),
    .a     (x_q[0]),
    .b     (x_q[1]),
    .c     (x_q[2]),
    .d     (x_q[3]),
    .y     (dft_w)
  );

  // stages 3 and 4: twiddle multiply, or a plain delay for the unity lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_unity
      r4bf_delay #(.W(WW), .STAGES(2)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_w),
        .d     (dft_w[k]),
        .q     (res_w[k])
      );
    end else begin : g_twiddle
      r4bf_delay #(.W(WW), .STAGES(1)) u_walign (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_w),
        .d     (w_q[k-1]),
        .q     (w_al[k-1])
      );
      r4bf_twmul u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_w),
        .x     (dft_w[k]),
        .w     (w_al[k-1]),
        .y     (res_w[k])
      );
    end
  end

  assign out_y0 = res_w[0];
  assign out_y1 = res_w[1];
  assign out_y2 = res_w[2];
  assign out_y3 = res_w[3];

endmodule

// File: rtl/r4bf_chk.sv
module r4bf_chk import r4bf_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [WW-1:0] in_x0,
  input logic [WW-1:0] in_x1,
  input logic [WW-1:0] in_x2,
  input logic [WW-1:0] in_x3,
  input logic [WW-1:0] out_y0,
  input logic [WW-1:0] out_y1,
  input logic [WW-1:0] out_y2,
  input logic [WW-1:0] out_y3
);

  function automatic logic [WW-1:0] quarter_sum(input logic [WW-1:0] a, input logic [WW-1:0] b,
                                                input logic [WW-1:0] c, input logic [WW-1:0] d);
    int re, im;
    re = int'($signed(a[WW-1:CW])) + int'($signed(b[WW-1:CW]))
       + int'($signed(c[WW-1:CW])) + int'($signed(d[WW-1:CW]));
    im = int'($signed(a[CW-1:0])) + int'($signed(b[CW-1:0]))
       + int'($signed(c[CW-1:0])) + int'($signed(d[CW-1:0]));
    re = re >>> SCALE;
    im = im >>> SCALE;
    return {re[CW-1:0], im[CW-1:0]};
  endfunction

  logic          take_w, give_w;
  logic [2:0]    occ_q;
  logic [2:0]    age_q;
  logic [WW-1:0] exp0_w;

  assign take_w = in_valid && in_ready;
  assign give_w = out_valid && out_ready;
  assign exp0_w = quarter_sum(in_x0, in_x1, in_x2, in_x3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      age_q <= '0;
    end else begin
      occ_q <= occ_q + 3'(take_w) - 3'(give_w);
      if (age_q != 3'd4) age_q <= age_q + 3'd1;
    end
  end

  // R10
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R9
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y0) && $stable(out_y1)
                                   && $stable(out_y2) && $stable(out_y3)));

  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 3'd4);

  // R8
  valid_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ_q != 3'd0));

  // R2
  unity_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && $past(take_w, 4) && $past(in_ready, 3) && $past(in_ready, 2)
     && $past(in_ready, 1)) |-> (out_valid && out_y0 == $past(exp0_w, 4)));

endmodule

bind r4bf_butterfly r4bf_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_x0     (in_x0),
  .in_x1     (in_x1),
  .in_x2     (in_x2),
  .in_x3     (in_x3),
  .out_y0    (out_y0),
  .out_y1    (out_y1),
  .out_y2    (out_y2),
  .out_y3    (out_y3)
);

// File: tb/r4bf_butterfly_tb_top.sv
module r4bf_butterfly_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_x0, in_x1, in_x2, in_x3, in_w1, in_w2, in_w3;
  logic [31:0] out_y0, out_y1, out_y2, out_y3;

  r4bf_butterfly dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2), .in_x3(in_x3),
    .in_w1(in_w1), .in_w2(in_w2), .in_w3(in_w3),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2), .out_y3(out_y3)
  );

  typedef struct {
    logic [3:0][31:0] y;
    int               acc_cyc;
    int               snap;
    string            tag;
  } exp_t;

  exp_t             exp_q[$];
  int               checks = 0, fails = 0, cyc = 0, stalls = 0;
  bit               done = 1'b0, held_vld = 1'b0;
  logic [3:0][31:0] held_y, last_y;
  string            lane_tag [4] = '{"R2", "R4", "R3", "R5"};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference ----------------
  function automatic int hr(input logic [31:0] v); return int'($signed(v[31:16])); endfunction
  function automatic int hi(input logic [31:0] v); return int'($signed(v[15:0]));  endfunction
  function automatic logic [31:0] pk(input int re, input int im);
    logic [31:0] r;
    r[31:16] = re[15:0];
    r[15:0]  = im[15:0];
    return r;
  endfunction

  function automatic int tw(input int xr, input int xi, input int c, input int s, input bit want_im);
    longint t;
    if (want_im) t = longint'(xi) * c - longint'(xr) * s;
    else         t = longint'(xr) * c + longint'(xi) * s;
    t = (t + 16384) >>> 15;
    if (t > 32767)  t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  function automatic logic [3:0][31:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] c, input logic [31:0] d, input logic [31:0] w1,
      input logic [31:0] w2, input logic [31:0] w3);
    int sr [4];
    int si [4];
    logic [31:0] w [4];
    logic [3:0][31:0] r;
    w[0] = 32'h7FFF_0000; w[1] = w1; w[2] = w2; w[3] = w3;
    sr[0] = hr(a) + hr(b) + hr(c) + hr(d);  si[0] = hi(a) + hi(b) + hi(c) + hi(d);
    sr[1] = hr(a) + hi(b) - hr(c) - hi(d);  si[1] = hi(a) - hr(b) - hi(c) + hr(d);
    sr[2] = hr(a) - hr(b) + hr(c) - hr(d);  si[2] = hi(a) - hi(b) + hi(c) - hi(d);
    sr[3] = hr(a) - hi(b) - hr(c) + hi(d);  si[3] = hi(a) + hr(b) - hi(c) - hr(d);
    for (int k = 0; k < 4; k++) begin
      sr[k] = sr[k] >>> 2;
      si[k] = si[k] >>> 2;
    end
    r[0] = pk(sr[0], si[0]);
    for (int k = 1; k < 4; k++)
      r[k] = pk(tw(sr[k], si[k], hr(w[k]), hi(w[k]), 1'b0),
                tw(sr[k], si[k], hr(w[k]), hi(w[k]), 1'b1));
    return r;
  endfunction

  // ---------------- one clock of stimulus and comparison ----------------
  task automatic step(input bit iv, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] c, input logic [31:0] d, input logic [31:0] w1,
                      input logic [31:0] w2, input logic [31:0] w3, input bit ordy,
                      input string tag);
    logic [3:0][31:0] cur;
    exp_t e;
    @(negedge clk);
    in_valid = iv; in_x0 = a; in_x1 = b; in_x2 = c; in_x3 = d;
    in_w1 = w1; in_w2 = w2; in_w3 = w3; out_ready = ordy;
    #1;
    cur = {out_y3, out_y2, out_y1, out_y0};
    check(in_ready == (!out_valid || out_ready), "R9", "ready rule",
          {31'b0, in_ready}, {31'b0, (!out_valid || out_ready)});
    if (held_vld) begin
      check(out_valid, "R9", "valid held under stall", {31'b0, out_valid}, 32'd1);
      for (int k = 0; k < 4; k++)
        check(cur[k] == held_y[k], "R9", "data held under stall", cur[k], held_y[k]);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "output with nothing accepted", cur[0], 32'd0);
      end else begin
        e = exp_q.pop_front();
        for (int k = 0; k < 4; k++)
          check(cur[k] == e.y[k], (e.tag != "") ? e.tag : lane_tag[k],
                $sformatf("result %0d", k), cur[k], e.y[k]);
        check((cyc - e.acc_cyc) == (4 + stalls - e.snap), "R8", "latency",
              cyc - e.acc_cyc, 4 + stalls - e.snap);
        last_y = cur;
      end
    end
    held_vld = out_valid && !out_ready;
    if (held_vld) begin
      held_y = cur;
      stalls++;
    end
    if (in_valid && in_ready) begin
      e.y = model(a, b, c, d, w1, w2, w3);
      e.acc_cyc = cyc;
      e.snap = stalls;
      e.tag = tag;
      exp_q.push_back(e);
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, '0, '0, '0, '0, '0, '0, '0, 1'b1, "");
  endtask

  localparam logic [31:0] ONE = 32'h7FFF_0000;

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_x0 = '0; in_x1 = '0; in_x2 = '0; in_x3 = '0;
    in_w1 = '0; in_w2 = '0; in_w3 = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R10", "out_valid during reset", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R10", "out_valid after reset", {31'b0, out_valid}, 32'd0);
    check(in_ready, "R10", "in_ready after reset", {31'b0, in_ready}, 32'd1);

    // R1: real-only impulse, all four results equal 4096 + j0
    step(1'b1, 32'h4000_0000, '0, '0, '0, ONE, ONE, ONE, 1'b1, "R1");
    idle(6);
    check(last_y[0] == 32'h1000_0000, "R1", "real impulse result 0", last_y[0], 32'h1000_0000);
    check(last_y[2] == 32'h1000_0000, "R1", "real impulse result 2", last_y[2], 32'h1000_0000);

    // R1: imaginary-only impulse lands in the low half
    step(1'b1, 32'h0000_4000, '0, '0, '0, ONE, ONE, ONE, 1'b1, "R1");
    idle(6);
    check(last_y[0] == 32'h0000_1000, "R1", "imag impulse result 0", last_y[0], 32'h0000_1000);
    check(last_y[1] == 32'h0000_1000, "R1", "imag impulse result 1", last_y[1], 32'h0000_1000);

    // R6: full-scale negative inputs must not wrap
    step(1'b1, 32'h8000_8000, 32'h8000_8000, 32'h8000_8000, 32'h8000_8000,
         ONE, ONE, ONE, 1'b1, "R6");
    idle(6);
    check(last_y[0] == 32'h8000_8000, "R6", "full-scale sum", last_y[0], 32'h8000_8000);

    // R6: largest rotated sum in result 1 (real part 131070 before the shift)
    step(1'b1, 32'h7FFF_0000, 32'h0000_7FFF, 32'h8000_0000, 32'h0000_8000,
         ONE, ONE, ONE, 1'b1, "R6");
    idle(6);

    // R7: (-1) * (-1) clamps to 32767; floor shift gives -1 on result 0
    step(1'b1, 32'h8000_0000, 32'h7FFF_0000, 32'h8000_0000, 32'h7FFF_0000,
         ONE, 32'h8000_0000, ONE, 1'b1, "R7");
    idle(6);
    check(last_y[2] == 32'h7FFF_0000, "R7", "clamped product", last_y[2], 32'h7FFF_0000);
    check(last_y[0] == 32'hFFFF_0000, "R6", "floor of -2/4", last_y[0], 32'hFFFF_0000);

    // R8: back-to-back burst, one per cycle
    for (int i = 0; i < 16; i++)
      step(1'b1, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
           1'b1, "");
    idle(6);

    // random traffic with random back-pressure
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 3) != 0, $urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, $urandom_range(0, 3) != 0, "");
    idle(12);
    check(exp_q.size() == 0, "R8", "all accepted butterflies delivered",
          exp_q.size(), 32'd0);
    finish_run();
  end

endmodule